// File: doc/BRIEF.md
# Dual-Bus Decode and Ready Generator

This block sits beside a 32-bit processor whose bus cycles can go either to local memory and I/O devices or to a slower 16-bit shared system bus. At the start of each bus cycle it decodes the cycle address and type, and it holds the result for the whole cycle. System-bus cycles get a bus-size-16 indication back to the processor, and they get an enable for the system-bus command controller and arbiter. Every other cycle raises a local memory select or a local I/O select.

A wait-state counter runs during every cycle and raises one strobe per wait state. Local cycles receive the processor ready after a fixed, parameterised number of wait states. System-bus cycles receive ready only once the remote device's transfer acknowledge has passed a synchroniser. The first two wait-state strobes also form the early read and write status outputs that the system-bus command controller needs.

Top module: `dbr_ready_gen`

## Requirements
- R1: A memory cycle (`cyc_mem`=1) whose address has bits [25:18] equal to 8'h3C (the default region 0F00000h to 0F3FFFFh) is a system-bus cycle. For that cycle `sys_en` is 1 and `bs16_n` is 0.
- R2: Any other cycle is local. A memory cycle raises `lmem_sel` and an I/O cycle raises `lio_sel`, and this includes I/O cycles to the region address. In a local cycle `sys_en` is 0 and `bs16_n` is 1. At most one of `sys_en`, `lmem_sel` and `lio_sel` is high.
- R3: The decode is captured at the clock edge that samples `ads_n` low while the block is idle. It is held until the cycle ends. Address changes and further `ads_n` pulses during a cycle have no effect.
- R4: In a local cycle, `rdy_n` is low only in clock cycle LOC_WS after the start edge. Cycle 0 is the cycle just after that edge.
- R5: `ws_strb[j]` is high only in clock cycle j+1 after the start edge, which is wait state j+1. At most one strobe is high at a time, and all strobes are low when idle.
- R6: In a system-bus cycle, `rdy_n` goes low only once `xack_n` has been low for SYNC_STAGES clock edges. If `xack_n` is first driven low in cycle d, ready appears in cycle d+SYNC_STAGES. `xack_n` has no effect on local cycles.
- R7: In a system-bus write, `st_wr_n` is low in wait states 1 and 2 only. A system-bus read does the same on `st_rd_n`. Both stay high during local cycles and when idle.
- R8: `rdy_n` is low for exactly one clock per cycle. In the next cycle the block is idle: `rdy_n`, `bs16_n`, `st_rd_n` and `st_wr_n` are 1, and `sys_en`, both local selects and all strobes are 0.
- R9: After reset the block is idle, with the outputs as listed in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ads_n | input | 1 | Cycle start strobe, active low |
| addr | input | 26 | Cycle address |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| xack_n | input | 1 | Remote transfer acknowledge, asynchronous, active low |
| rdy_n | output | 1 | Processor ready, active low |
| bs16_n | output | 1 | 16-bit bus size request, active low |
| sys_en | output | 1 | System-bus controller and arbiter enable |
| lmem_sel | output | 1 | Local memory select |
| lio_sel | output | 1 | Local I/O select |
| ws_strb | output | 7 | One strobe per wait state |
| st_rd_n | output | 1 | Early read status for the system bus, active low |
| st_wr_n | output | 1 | Early write status for the system bus, active low |

## Verification
Two things can fall in the same clock: a change on the acknowledge input and the local wait-state count reaching its terminal value. The bench provokes this by pulling `xack_n` low at the start of local cycles. It then checks that ready still appears at exactly the LOC_WS count. A new start strobe can also coincide with a cycle already in progress, so the bench pulses `ads_n` with a different address and cycle type in the first clock of a cycle. It checks that the decode outputs, the strobes and the ready timing all follow the original cycle.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SYS  = 2'd1,
      TGT_LMEM = 2'd2,
      TGT_LIO  = 2'd3
   } tgt_e;

   function automatic logic region_hit(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] mask);
      return ((a ^ base) & mask) == 32'd0;
   endfunction

endpackage

// File: rtl/dbr_addr_decode.sv
module dbr_addr_decode
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 26,
   parameter logic [31:0] SYS_BASE     = 32'h00F0_0000,
   parameter logic [31:0] SYS_MASK     = 32'h03FC_0000,
   parameter bit          SYS_MEM_ONLY = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              cyc_mem,
   output tgt_e              tgt
);
   localparam int unsigned PAD_W = 32 - ADDR_W;

   logic [31:0] addr_ext;
   logic        in_region;
   logic        sys_hit;

   generate
      if (ADDR_W < 32) begin : g_pad
         assign addr_ext = {{PAD_W{1'b0}}, addr};
      end else begin : g_nopad
         assign addr_ext = addr[31:0];
      end
   endgenerate

   assign in_region = region_hit(addr_ext, SYS_BASE, SYS_MASK);

   generate
      if (SYS_MEM_ONLY) begin : g_mem_only
         assign sys_hit = in_region & cyc_mem;
      end else begin : g_any_space
         assign sys_hit = in_region;
      end
   endgenerate

   always_comb begin
      if (sys_hit)      tgt = TGT_SYS;
      else if (cyc_mem) tgt = TGT_LMEM;
      else              tgt = TGT_LIO;
   end

endmodule

// File: rtl/dbr_xack_sync.sv
module dbr_xack_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_n
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b1;
      else        chain_q[0] <= async_n;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dbr_ws_counter.sv
module dbr_ws_counter #(
   parameter int unsigned NSTRB = 7,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   output logic [CNT_W-1:0] count,
   output logic [NSTRB-1:0] strb
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NSTRB + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (start)                    cnt_q <= '0;
      else if (run && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
   end

   generate
      for (genvar j = 0; j < NSTRB; j++) begin : g_strb
         assign strb[j] = run && (cnt_q == CNT_W'(j + 1));
      end
   endgenerate

   assign count = cnt_q;

endmodule

// File: rtl/dbr_ready_gen.sv
module dbr_ready_gen
   import dbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 26,
   parameter logic [31:0] SYS_BASE     = 32'h00F0_0000,
   parameter logic [31:0] SYS_MASK     = 32'h03FC_0000,
   parameter bit          SYS_MEM_ONLY = 1'b1,
   parameter int unsigned LOC_WS       = 3,
   parameter int unsigned NSTRB        = 7,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ads_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cyc_mem,
   input  logic              cyc_wr,
   input  logic              xack_n,
   output logic              rdy_n,
   output logic              bs16_n,
   output logic              sys_en,
   output logic              lmem_sel,
   output logic              lio_sel,
   output logic [NSTRB-1:0]  ws_strb,
   output logic              st_rd_n,
   output logic              st_wr_n
);
   localparam int unsigned CNT_W = $clog2(NSTRB + 2);
   localparam logic [CNT_W-1:0] LOC_DONE = CNT_W'(LOC_WS);

   generate
      if (LOC_WS > 7)         begin : g_err_ws   $error("LOC_WS must be 0..7");           end
      if (LOC_WS > NSTRB)     begin : g_err_cov  $error("NSTRB must cover LOC_WS");        end
      if (NSTRB < 2)          begin : g_err_st   $error("NSTRB must be at least 2");       end
      if (SYNC_STAGES < 2)    begin : g_err_sy   $error("SYNC_STAGES must be at least 2"); end
      if (ADDR_W > 32 || ADDR_W < 8) begin : g_err_aw $error("ADDR_W must be 8..32");      end
   endgenerate

   tgt_e             tgt_d;
   tgt_e             tgt_q;
   logic             active_q;
   logic             wr_q;
   logic             start;
   logic             ready_hit;
   logic             xack_s_n;
   logic [CNT_W-1:0] wcnt;
   logic             early_ws;

   dbr_addr_decode #(
      .ADDR_W      (ADDR_W),
      .SYS_BASE    (SYS_BASE),
      .SYS_MASK    (SYS_MASK),
      .SYS_MEM_ONLY(SYS_MEM_ONLY)
   ) dec_i (
      .addr   (addr),
      .cyc_mem(cyc_mem),
      .tgt    (tgt_d)
   );

   dbr_xack_sync #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_n(xack_n),
      .sync_n (xack_s_n)
   );

   assign start = !ads_n && !active_q;

   dbr_ws_counter #(
      .NSTRB(NSTRB),
      .CNT_W(CNT_W)
   ) cnt_i (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .run  (active_q),
      .count(wcnt),
      .strb (ws_strb)
   );

   always_comb begin
      ready_hit = 1'b0;
      if (active_q) begin
         if (tgt_q == TGT_SYS) ready_hit = !xack_s_n;
         else                  ready_hit = (wcnt == LOC_DONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         tgt_q    <= TGT_NONE;
         wr_q     <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         tgt_q    <= tgt_d;
         wr_q     <= cyc_wr;
      end else if (ready_hit) begin
         active_q <= 1'b0;
         tgt_q    <= TGT_NONE;
      end
   end

   assign early_ws = ws_strb[0] | ws_strb[1];

   assign rdy_n    = !ready_hit;
   assign sys_en   = active_q && (tgt_q == TGT_SYS);
   assign bs16_n   = !sys_en;
   assign lmem_sel = active_q && (tgt_q == TGT_LMEM);
   assign lio_sel  = active_q && (tgt_q == TGT_LIO);
   assign st_rd_n  = !(sys_en && early_ws && !wr_q);
   assign st_wr_n  = !(sys_en && early_ws && wr_q);

endmodule

// File: rtl/dbr_ready_gen_chk.sv
module dbr_ready_gen_chk #(
   parameter int unsigned NSTRB  = 7,
   parameter int unsigned LOC_WS = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rdy_n,
   input logic             bs16_n,
   input logic             sys_en,
   input logic             lmem_sel,
   input logic             lio_sel,
   input logic [NSTRB-1:0] ws_strb,
   input logic             st_rd_n,
   input logic             st_wr_n,
   input logic             xack_s_n
);
   p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sys_en, lmem_sel, lio_sel}));

   p_bs16_tracks_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bs16_n == !sys_en);

   p_hold_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_en && rdy_n) |=> sys_en);

   p_hold_loc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((lmem_sel || lio_sel) && rdy_n) |=> ($stable(lmem_sel) && $stable(lio_sel)));

   p_strb_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ws_strb));

   p_sys_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && sys_en) |-> !xack_s_n);

   p_status_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_rd_n || !st_wr_n) |-> (sys_en && (ws_strb[0] || ws_strb[1])));

   p_one_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_n |=> (rdy_n && !sys_en && !lmem_sel && !lio_sel));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_en && !lmem_sel && !lio_sel) |-> (rdy_n && ws_strb == '0));

   generate
      if (LOC_WS > 0) begin : g_loc_ws
         p_loc_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!rdy_n && (lmem_sel || lio_sel)) |-> ws_strb[LOC_WS-1]);
      end else begin : g_loc_zero
         p_loc_nowait_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!rdy_n && (lmem_sel || lio_sel)) |-> (ws_strb == '0));
      end
   endgenerate

endmodule

bind dbr_ready_gen dbr_ready_gen_chk #(
   .NSTRB (NSTRB),
   .LOC_WS(LOC_WS)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .rdy_n   (rdy_n),
   .bs16_n  (bs16_n),
   .sys_en  (sys_en),
   .lmem_sel(lmem_sel),
   .lio_sel (lio_sel),
   .ws_strb (ws_strb),
   .st_rd_n (st_rd_n),
   .st_wr_n (st_wr_n),
   .xack_s_n(xack_s_n)
);

// File: tb/dbr_ready_gen_tb_top.sv
module dbr_ready_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 26;
   localparam int LWS   = 3;
   localparam int NS    = 7;
   localparam int SYNC  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ads_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          cyc_mem = 1'b1;
   logic          cyc_wr = 1'b0;
   logic          xack_n = 1'b1;
   logic          rdy_n, bs16_n, sys_en, lmem_sel, lio_sel, st_rd_n, st_wr_n;
   logic [NS-1:0] ws_strb;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbr_ready_gen #(.LOC_WS(LWS), .NSTRB(NS), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .addr(addr), .cyc_mem(cyc_mem),
      .cyc_wr(cyc_wr), .xack_n(xack_n), .rdy_n(rdy_n), .bs16_n(bs16_n),
      .sys_en(sys_en), .lmem_sel(lmem_sel), .lio_sel(lio_sel), .ws_strb(ws_strb),
      .st_rd_n(st_rd_n), .st_wr_n(st_wr_n));

   function automatic bit exp_sys(input logic [AW-1:0] a, input bit mem);
      return mem && (a[25:18] == 8'h3C);
   endfunction

   function automatic logic [NS-1:0] exp_strb(input int k);
      return (k >= 1 && k <= NS) ? NS'(1) << (k - 1) : '0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(rdy_n == 1'b1,  req, "rdy_n idle", 32'(rdy_n), 1);
      chk(bs16_n == 1'b1, req, "bs16_n idle", 32'(bs16_n), 1);
      chk({sys_en, lmem_sel, lio_sel} == 3'b000, req, "selects idle",
          32'({sys_en, lmem_sel, lio_sel}), 0);
      chk(ws_strb == '0, req, "strobes idle", 32'(ws_strb), 0);
      chk({st_rd_n, st_wr_n} == 2'b11, req, "status idle", 32'({st_rd_n, st_wr_n}), 3);
   endtask

   task automatic run_cycle(input logic [AW-1:0] a, input bit mem, input bit w,
                            input int xdly, input bit noise, input bit extra_ads);
      bit is_sys;
      int rdy_at;
      logic [NS-1:0] es;
      bit early;
      is_sys = exp_sys(a, mem);
      rdy_at = is_sys ? xdly + SYNC : LWS;
      @(negedge clk);
      ads_n = 1'b0; addr = a; cyc_mem = mem; cyc_wr = w;
      @(negedge clk);
      ads_n = 1'b1; addr = ~a; cyc_mem = ~mem; cyc_wr = ~w;  // R3: inputs move mid-cycle
      for (int k = 0; k <= rdy_at; k++) begin
         if (k > 0) @(negedge clk);
         es = exp_strb(k);
         early = is_sys && (k == 1 || k == 2);
         if (is_sys)
            chk(rdy_n == (k != rdy_at), "R6", "sys rdy_n", 32'(rdy_n), 32'(k != rdy_at));
         else
            chk(rdy_n == (k != rdy_at), "R4", "local rdy_n", 32'(rdy_n), 32'(k != rdy_at));
         chk(ws_strb == es, "R5", "strobes", 32'(ws_strb), 32'(es));
         chk(sys_en == is_sys && bs16_n == !is_sys, "R1", "sys_en/bs16_n",
             32'({sys_en, bs16_n}), 32'({is_sys, !is_sys}));
         chk(lmem_sel == (!is_sys && mem) && lio_sel == (!is_sys && !mem), "R2",
             "local selects", 32'({lmem_sel, lio_sel}),
             32'({!is_sys && mem, !is_sys && !mem}));
         if (extra_ads && k >= 1)
            chk({sys_en, lmem_sel, lio_sel} == {is_sys, !is_sys && mem, !is_sys && !mem},
                "R3", "decode held", 32'({sys_en, lmem_sel, lio_sel}),
                32'({is_sys, !is_sys && mem, !is_sys && !mem}));
         chk(st_wr_n == !(early && w) && st_rd_n == !(early && !w), "R7", "status",
             32'({st_rd_n, st_wr_n}), 32'({!(early && !w), !(early && w)}));
         if (is_sys && k == xdly) xack_n = 1'b0;
         if (!is_sys && noise && k == 0) xack_n = 1'b0;  // R6: ignored in local cycle
         if (extra_ads && k == 0) begin
            ads_n = 1'b0; addr = a ^ 26'h0F00000; cyc_mem = ~mem;
         end
         if (extra_ads && k == 1) ads_n = 1'b1;
      end
      xack_n = 1'b1; ads_n = 1'b1;
      @(negedge clk);
      chk_idle("R8");
      repeat (SYNC + 1) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk_idle("R9");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R9");
      // directed region boundaries
      run_cycle(26'h0F00000, 1'b1, 1'b0, 0, 1'b0, 1'b0);  // R1 low edge, read
      run_cycle(26'h0F3FFFF, 1'b1, 1'b1, 3, 1'b0, 1'b0);  // R1 high edge, write
      run_cycle(26'h0F40000, 1'b1, 1'b0, 0, 1'b0, 1'b0);  // R2 just above
      run_cycle(26'h0EFFFFF, 1'b1, 1'b1, 0, 1'b0, 1'b0);  // R2 just below
      run_cycle(26'h0F10000, 1'b0, 1'b0, 0, 1'b0, 1'b0);  // R2 I/O into region
      run_cycle(26'h2F00000, 1'b1, 1'b0, 0, 1'b0, 1'b0);  // R2 upper alias
      // coincidences: ack during local count, start pulse during a cycle
      run_cycle(26'h0001234, 1'b1, 1'b0, 0, 1'b1, 1'b0);  // R6 ack ignored
      run_cycle(26'h0F20000, 1'b1, 1'b1, 5, 1'b0, 1'b1);  // R3 sys
      run_cycle(26'h0000100, 1'b0, 1'b1, 0, 1'b1, 1'b1);  // R3 local io
      run_cycle(26'h0F00000, 1'b1, 1'b0, 9, 1'b0, 1'b0);  // R5 past last strobe
      for (int n = 0; n < 300; n++) begin
         logic [AW-1:0] ra;
         ra = ($urandom % 5 < 2) ? (26'h0F00000 | AW'($urandom & 32'h3FFFF)) : AW'($urandom);
         run_cycle(ra, ($urandom % 4) != 0, $urandom % 2 == 1, int'($urandom % 7),
                   $urandom % 3 == 0, $urandom % 4 == 0);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule